// File: doc/BRIEF.md
# PHY Board Control and Identification Decoder

This block sits on a small strobed microprocessor bus (9-bit address, 8-bit data, active-low chip select, read and write strobes) in front of a line-interface PHY board. It decodes the upper half of the address space itself and passes the lower half through to the PHY device as a chip select. The top 32 bytes form a read-only identification window. That window describes the board's framing protocol, cable medium, capability octets, node address, and a vendor and part-number string.

Two write-only control bits are decoded from the top four address bits alone, and the five low address bits are ignored. One bit holds the downstream PHY, receive FIFO and glue logic in reset. The other selects a diagnostic transmit-to-receive loopback. Only data bit 0 of a write matters. The hardware reset input clears both bits.

The bus is asynchronous to the block's clock. The write strobe is synchronized, and a write is committed once, on the synchronized assertion of chip select together with the write strobe. Reads are combinational from the address and strobes. The read data comes with an output-enable that stands in for a tri-state driver. The bus is a plain strobed interface with no back-pressure: the host must keep the address and data stable while the write strobe is low, and must hold the write strobe low for at least 4 clock cycles.

Top module: `phy_board_ctl`

## Requirements
- R1: While rst_n is low, hold_rst and loop_sel are 0, even when both were set before the reset.
- R2: Reads at 0x1E0, 0x1E1, 0x1E2 and 0x1E3 return 0x0C, 0x01, 0x21 and 0x0C respectively, with rdata_oe high.
- R3: Reads anywhere in 0x1E4 to 0x1EF (the 8-byte node address, stored most significant byte first, followed by 4 reserved bytes) return 0x00.
- R4: Reads at 0x1F0 to 0x1F2 return the ASCII characters "GEN", and reads at 0x1F3 to 0x1FF return the ASCII characters "OC3-UTP5-CARD". In both strings, the lower address holds the earlier character.
- R5: A write to any address whose bits [8:5] are 1110 (0x1C0 to 0x1DF) sets hold_rst to wdata[0]. Bits [7:1] of wdata have no effect. The new value appears no later than 3 clock cycles after cs_n and wr_n are both low.
- R6: A write to any address whose bits [8:5] are 1111 (0x1E0 to 0x1FF) sets loop_sel to wdata[0], with the same timing as R5. The identification bytes read back unchanged afterwards.
- R7: Reads in 0x1C0 to 0x1DF return 0x00 with rdata_oe high. rdata_oe is high only when cs_n and rd_n are low and address bits [8:6] are 111.
- R8: phy_cs_n is low exactly when cs_n is low and address bit 8 is 0. In that case rdata_oe stays low.
- R9: Writes to 0x000 to 0x1BF and read cycles of any address leave hold_rst and loop_sel unchanged. Reads in 0x100 to 0x1BF leave rdata_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to synchronize the write strobe |
| rst_n | input | 1 | Active-low hardware reset; clears both control bits |
| cs_n | input | 1 | Active-low bus chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 9 | Bus address |
| wdata | input | 8 | Write data; only bit 0 is used |
| rdata | output | 8 | Read data (0x00 when not driving) |
| rdata_oe | output | 1 | High when this block drives the data bus |
| phy_cs_n | output | 1 | Active-low chip select passed to the PHY device's register space |
| hold_rst | output | 1 | Holds the PHY, FIFO and glue logic in reset while high |
| loop_sel | output | 1 | Selects the diagnostic transmit loopback while high |

## Verification
The bench focuses on address aliasing. It writes to both control bits at random low-address bits and with random upper data bits. A decoder that compared the whole address, or used the whole data byte, would leave a bit unchanged or set it wrongly. It writes into the identification window and then reads the window back. A window built as writable storage would return the written byte, and a window whose loopback decode was missing would leave loop_sel unchanged. It also applies a hardware reset while both bits are set, and reads the boundary addresses 0x0FF, 0x100, 0x1BF, 0x1C0, 0x1DF and 0x1EF. A design with an off-by-one region decode would drive the bus or the PHY select at the wrong address.

// File: rtl/phyb_pkg.sv
package phyb_pkg;

  // Address regions, decoded from the top four address bits
  typedef enum logic [1:0] {
    RGN_PHY      = 2'd0,  // lower half: PHY device register space
    RGN_UNMAPPED = 2'd1,  // upper half below the control window
    RGN_RSTCTL   = 2'd2,  // top4 == 1110: hold-reset bit, reads zero
    RGN_IDLOOP   = 2'd3   // top4 == 1111: loopback bit, ID bytes on read
  } region_e;

  localparam int unsigned ID_BYTES   = 32;
  localparam int unsigned ID_OFF_W   = $clog2(ID_BYTES);
  localparam int unsigned VENDOR_LEN = 3;
  localparam int unsigned PART_LEN   = 13;
  localparam int unsigned NODE_LEN   = 8;
  localparam int unsigned RSVD_LEN   = 4;

endpackage

// File: rtl/addr_region.sv
module addr_region
  import phyb_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);

  localparam int unsigned TOP_W = 4;

  logic [TOP_W-1:0] top;
  assign top = addr_i[ADDR_W-1 -: TOP_W];

  always_comb begin
    if (!top[TOP_W-1])           region_o = RGN_PHY;
    else if (top == 4'b1110)     region_o = RGN_RSTCTL;
    else if (top == 4'b1111)     region_o = RGN_IDLOOP;
    else                         region_o = RGN_UNMAPPED;
  end

endmodule

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic rise_o
);

  // STAGES synchronizer flops plus one more for edge detection
  logic [STAGES:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[STAGES-1:0], act_i};
  end

  assign rise_o = q[STAGES-1] & ~q[STAGES];

endmodule

// File: rtl/id_rom.sv
module id_rom
  import phyb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0]            PROTO_CODE = 8'h0C,
  parameter logic [DATA_W-1:0]            MEDIA_CODE = 8'h01,
  parameter logic [DATA_W-1:0]            CAP_FIRST  = 8'h21,
  parameter logic [DATA_W-1:0]            CAP_SECOND = 8'h0C,
  parameter logic [NODE_LEN*DATA_W-1:0]   NODE_ID    = '0,
  parameter logic [VENDOR_LEN*DATA_W-1:0] VENDOR_STR = "GEN",
  parameter logic [PART_LEN*DATA_W-1:0]   PART_STR   = "OC3-UTP5-CARD"
) (
  input  logic [ID_OFF_W-1:0] off_i,
  output logic [DATA_W-1:0]   byte_o
);

  localparam int unsigned IMG_W = ID_BYTES * DATA_W;

  // Lowest offset sits in the most significant byte of the image
  localparam logic [IMG_W-1:0] IMAGE = {
    PROTO_CODE, MEDIA_CODE, CAP_FIRST, CAP_SECOND,
    NODE_ID, {(RSVD_LEN*DATA_W){1'b0}},
    VENDOR_STR, PART_STR
  };

  logic [DATA_W-1:0] rom_q [ID_BYTES];

  for (genvar i = 0; i < ID_BYTES; i++) begin : g_byte
    assign rom_q[i] = IMAGE[IMG_W-1-i*DATA_W -: DATA_W];
  end

  assign byte_o = rom_q[off_i];

endmodule

// File: rtl/ctrl_bits.sv
module ctrl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  input  logic sel_rst_i,
  input  logic sel_loop_i,
  input  logic bit_i,
  output logic hold_rst_o,
  output logic loop_sel_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_rst_o <= 1'b0;
      loop_sel_o <= 1'b0;
    end else if (commit_i) begin
      if (sel_rst_i)  hold_rst_o <= bit_i;
      if (sel_loop_i) loop_sel_o <= bit_i;
    end
  end

endmodule

// File: rtl/phy_board_ctl.sv
module phy_board_ctl
  import phyb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              phy_cs_n,
  output logic              hold_rst,
  output logic              loop_sel
);

  region_e           region;
  logic              wr_act;
  logic              wr_commit;
  logic              rd_hit;
  logic [DATA_W-1:0] id_byte;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:1];

  addr_region #(.ADDR_W(ADDR_W)) u_region (
    .addr_i   (addr),
    .region_o (region)
  );

  assign wr_act = ~cs_n & ~wr_n;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_i  (wr_act),
    .rise_o (wr_commit)
  );

  ctrl_bits u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (wr_commit),
    .sel_rst_i  (region == RGN_RSTCTL),
    .sel_loop_i (region == RGN_IDLOOP),
    .bit_i      (wdata[0]),
    .hold_rst_o (hold_rst),
    .loop_sel_o (loop_sel)
  );

  id_rom #(.DATA_W(DATA_W)) u_rom (
    .off_i  (addr[ID_OFF_W-1:0]),
    .byte_o (id_byte)
  );

  assign rd_hit   = ~cs_n & ~rd_n &
                    ((region == RGN_RSTCTL) || (region == RGN_IDLOOP));
  assign rdata_oe = rd_hit;
  assign rdata    = (rd_hit && region == RGN_IDLOOP) ? id_byte : '0;
  assign phy_cs_n = ~(~cs_n & (region == RGN_PHY));

endmodule

// File: rtl/phy_board_ctl_chk.sv
module phy_board_ctl_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              phy_cs_n,
  input logic              hold_rst,
  input logic              loop_sel
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (!hold_rst && !loop_sel);
    end
  end

  // R5
  hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rst != $past(hold_rst)) |->
      $past(!cs_n && !wr_n && addr[ADDR_W-1 -: 4] == 4'b1110));

  // R6
  loop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_sel != $past(loop_sel)) |->
      $past(!cs_n && !wr_n && addr[ADDR_W-1 -: 4] == 4'b1111));

  // R7
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!cs_n && !rd_n && addr[ADDR_W-1 -: 3] == 3'b111));

  // R8
  phy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_cs_n |-> !rdata_oe);

  // R2
  proto_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && addr == 9'h1E0) |-> (rdata == 8'h0C));

endmodule

bind phy_board_ctl phy_board_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .addr     (addr),
  .rdata    (rdata),
  .rdata_oe (rdata_oe),
  .phy_cs_n (phy_cs_n),
  .hold_rst (hold_rst),
  .loop_sel (loop_sel)
);

// File: tb/phy_board_ctl_tb.sv
`timescale 1ns/1ps
module phy_board_ctl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe, phy_cs_n, hold_rst, loop_sel;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_hold = 0, m_loop = 0;

  always #2 clk = ~clk;

  phy_board_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .phy_cs_n(phy_cs_n), .hold_rst(hold_rst), .loop_sel(loop_sel)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] id_exp(input logic [4:0] off);
    string vend = "GEN";
    string part = "OC3-UTP5-CARD";
    case (off)
      5'd0: return 8'h0C;
      5'd1: return 8'h01;
      5'd2: return 8'h21;
      5'd3: return 8'h0C;
      default: begin
        if (off < 5'd16) return 8'h00;
        if (off < 5'd19) return vend[int'(off) - 16];
        return part[int'(off) - 19];
      end
    endcase
  endfunction

  function automatic logic oe_exp(input logic [8:0] a);
    return a[8:6] == 3'b111;
  endfunction

  function automatic logic [7:0] rd_exp(input logic [8:0] a);
    if (a[8:5] == 4'b1111) return id_exp(a[4:0]);
    return 8'h00;
  endfunction

  function automatic string rd_req(input logic [8:0] a);
    if (a[8:5] == 4'b1110) return "R7";
    if (a[8:5] != 4'b1111) return (a[8] ? "R9" : "R8");
    if (a[4:0] < 5'd4)  return "R2";
    if (a[4:0] < 5'd16) return "R3";
    return "R4";
  endfunction

  task automatic bus_read(input logic [8:0] a);
    @(negedge clk);
    addr = a; cs_n = 0; rd_n = 0;
    #1;
    check(rd_req(a), int'(rdata_oe), int'(oe_exp(a)));
    if (oe_exp(a)) check(rd_req(a), int'(rdata), int'(rd_exp(a)));
    check("R8", int'(phy_cs_n), int'(a[8]));
    @(negedge clk);
    cs_n = 1; rd_n = 1;
    @(negedge clk);
    check("R9", int'(hold_rst), int'(m_hold));
    check("R9", int'(loop_sel), int'(m_loop));
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [7:0] d);
    string req;
    @(negedge clk);
    addr = a; wdata = d; cs_n = 0; wr_n = 0;
    #1;
    check("R8", int'(phy_cs_n), int'(a[8]));
    repeat (4) @(negedge clk);
    cs_n = 1; wr_n = 1;
    if (a[8:5] == 4'b1110) begin m_hold = d[0]; req = "R5"; end
    else if (a[8:5] == 4'b1111) begin m_loop = d[0]; req = "R6"; end
    else req = "R9";
    repeat (3) @(negedge clk);
    check(req, int'(hold_rst), int'(m_hold));
    check(req, int'(loop_sel), int'(m_loop));
  endtask

  function automatic logic [8:0] pick_addr();
    case ($urandom % 5)
      0: return 9'h1C0 | 9'($urandom % 32);
      1: return 9'h1E0 | 9'($urandom % 32);
      2: return 9'($urandom % 256);
      3: return 9'h100 | 9'($urandom % 192);
      default: return 9'($urandom % 512);
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1 rst_n = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", int'(hold_rst), 0);
    check("R1", int'(loop_sel), 0);
    rst_n = 1;
    @(negedge clk);

    // Directed: whole ID window (R2 R3 R4)
    for (int i = 0; i < 32; i++) bus_read(9'h1E0 + 9'(i));
    // Boundaries (R7 R8 R9)
    bus_read(9'h0FF); bus_read(9'h100); bus_read(9'h1BF);
    bus_read(9'h1C0); bus_read(9'h1DF); bus_read(9'h1EF);

    // R5 with aliased address and upper data bits; R6 into ID window
    bus_write(9'h1D7, 8'hFE);
    bus_write(9'h1C3, 8'h01);
    bus_write(9'h1E0, 8'h55);
    bus_read(9'h1E0);              // R6: ID byte unchanged
    bus_write(9'h1FF, 8'hA0);
    bus_write(9'h1E5, 8'hFF);
    bus_write(9'h1BF, 8'h00);      // R9: just below window
    bus_write(9'h042, 8'h00);      // R9: PHY space

    // R1: hardware reset clears set bits
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R1", int'(hold_rst), 0);
    check("R1", int'(loop_sel), 0);
    m_hold = 0; m_loop = 0;
    rst_n = 1;
    @(negedge clk);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [8:0] a;
      a = pick_addr();
      if ($urandom % 2) bus_write(a, 8'($urandom));
      else              bus_read(a);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule